// File: doc/BRIEF.md
# UART Prioritized Interrupt Status Logic

This block collects every interrupt cause of a single UART channel, keeps the causes that need to be remembered, and presents the most urgent enabled one as an 8-bit status byte together with an active-high request line. The sources are:

- line-status error events;
- receive FIFO fill against its trigger;
- a receive idle time-out;
- transmit readiness;
- modem-status change events;
- an Xoff or special-character match, released by an Xon;
- rising edges on the CTS and RTS flow-control pins.

Each source has its own clearing rule. Some clear on a status-register read, some on the matching line-status or modem-status read, and some on a data access to the receive or transmit holding register.

The host bus decode turns its accesses into single-cycle strobes (status read, line-status read, modem-status read, receive-holding read, transmit-holding write) and feeds them in alongside the FIFO levels and the event pulses. The status byte is combinational from the internal state, so a host read in any cycle sees the current winner.

Top module: `uart_irq_status`

## Requirements
- R1: Asynchronous reset (rst_ni low) leaves no source pending: irq_o is 0 and status_o[5:0] is 6'b000001.
- R2: When several sources are enabled and pending, status_o[5:0] reports only the highest one. The order from highest to lowest is: line status, receive time-out, receive ready, transmit ready, modem status, Xoff/special, CTS/RTS change.
- R3: status_o[5:0] codes are: line status 000110, receive time-out 001100, receive ready 000100, transmit ready 000010, modem status 000000, Xoff/special 010000, CTS/RTS change 100000, and none 000001. Bit 0 is 0 exactly when irq_o is 1.
- R4: A cycle with any bit of lsr_evt_i set latches the line-status source. A cycle with lsr_rd_i high clears it, unless a new event arrives in the same cycle.
- R5: The receive-ready source is pending while rx_level_i >= rx_trig_i, and is gone as soon as the level drops below the trigger.
- R6: While rx_level_i is nonzero, the time-out source sets after L = 4*(7+wlen_i) + 12 cycles with baud_tick_i high and no rx_char_i or rhr_rd_i. A pulse on rx_char_i sets a count of zero, and the source sets at the L-th following tick edge. rhr_rd_i restarts the count and clears the source.
- R7: The transmit-ready source sets when (tx_empty_i or tx_level_i <= tx_trig_i), ANDed with ien_i[1], goes from 0 to 1. It clears on thr_wr_i, and also on isr_rd_i, but only while transmit ready is the reported source.
- R8: A cycle with any bit of msr_evt_i set latches the modem-status source. msr_rd_i clears it, and clears the CTS/RTS change source too.
- R9: With enh_i=1, xoff_match_i latches the Xoff source and a sticky flag. The flag keeps status_o[4] at 1 until xon_i. The Xoff source clears on isr_rd_i while it is the reported source.
- R10: A low-to-high change on cts_i while auto_cts_i=1, or on rts_i while auto_rts_i=1, latches the CTS/RTS change source, provided enh_i=1. Edges with the matching auto bit at 0 are ignored.
- R11: status_o[7:6] is 2'b11 when fifo_en_i=1 and 2'b00 when it is 0.
- R12: Enable bits ien_i gate reporting per source: [0] receive ready and time-out, [1] transmit ready, [2] line status, [3] modem status, [4] Xoff, [5] CTS/RTS change. With enh_i=0, status_o[5:4] stays 00 and the Xoff and CTS/RTS sources never raise irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFOs enabled |
| enh_i | input | 1 | Enhanced mode (Xoff and flow sources) |
| ien_i | input | 6 | Per-source interrupt enables |
| wlen_i | input | 2 | Word length setting, 0..3 = 5..8 data bits |
| baud_tick_i | input | 1 | One pulse per serial bit time |
| lsr_evt_i | input | 4 | Line-status error events |
| msr_evt_i | input | 4 | Modem-status change events |
| rx_level_i | input | LVL_W | Receive FIFO fill |
| rx_trig_i | input | LVL_W | Receive trigger level |
| rx_char_i | input | 1 | A character entered the receive FIFO |
| tx_level_i | input | LVL_W | Transmit FIFO fill |
| tx_trig_i | input | LVL_W | Transmit trigger level |
| tx_empty_i | input | 1 | Transmit FIFO empty |
| xoff_match_i | input | 1 | Xoff or special character matched |
| xon_i | input | 1 | Xon character received |
| cts_i | input | 1 | CTS pin level |
| rts_i | input | 1 | RTS pin level |
| auto_cts_i | input | 1 | Automatic CTS flow control on |
| auto_rts_i | input | 1 | Automatic RTS flow control on |
| isr_rd_i | input | 1 | Status register read strobe |
| lsr_rd_i | input | 1 | Line-status register read strobe |
| msr_rd_i | input | 1 | Modem-status register read strobe |
| rhr_rd_i | input | 1 | Receive holding register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| status_o | output | 8 | Interrupt status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its defaults: FIFO_DEPTH=128, which gives 8-bit level ports, and TOUT_W=6. A 6-bit count covers the largest time-out of 52 ticks. The time-out boundary is checked at word-length settings 0 and 3, which give limits of 40 and 52 ticks, with the tick held high every cycle so that both edges of the window are reached in a few dozen cycles. The 8-bit levels allow a trigger of 8 to be probed from just above to just below.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 7;

  // index = priority rank, 0 is highest
  typedef enum int {
    SRC_LINE  = 0,
    SRC_TOUT  = 1,
    SRC_RXRDY = 2,
    SRC_TXRDY = 3,
    SRC_MODEM = 4,
    SRC_XOFF  = 5,
    SRC_FLOW  = 6
  } src_e;

  localparam logic [5:0] CODE_NONE = 6'b000001;

  function automatic logic [5:0] src_code(input int idx);
    case (idx)
      SRC_LINE:  return 6'b000110;
      SRC_TOUT:  return 6'b001100;
      SRC_RXRDY: return 6'b000100;
      SRC_TXRDY: return 6'b000010;
      SRC_MODEM: return 6'b000000;
      SRC_XOFF:  return 6'b010000;
      SRC_FLOW:  return 6'b100000;
      default:   return CODE_NONE;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_rx_timeout.sv
module uart_irq_rx_timeout #(
  parameter int TOUT_W = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] wlen_i,
  input  logic       nonempty_i,
  input  logic       rx_char_i,
  input  logic       rhr_rd_i,
  output logic       tout_o
);
  localparam logic [TOUT_W-1:0] BASE = TOUT_W'(4 * 7 + 12);

  logic [TOUT_W-1:0] cnt_q, limit;
  logic              done_q;

  // 4 frames of (start + 5..8 data + stop) plus 12 bits
  assign limit = BASE + (TOUT_W'(wlen_i) << 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      tout_o <= 1'b0;
    end else begin
      if (rhr_rd_i) tout_o <= 1'b0;
      if (rx_char_i || rhr_rd_i || !nonempty_i) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (tick_i && !done_q) begin
        if (cnt_q == limit - 1'b1) begin
          done_q <= 1'b1;
          tout_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enh_i,
  input  logic [3:0] lsr_evt_i,
  input  logic       lsr_rd_i,
  input  logic [3:0] msr_evt_i,
  input  logic       msr_rd_i,
  input  logic       isr_rd_i,
  input  logic       thr_wr_i,
  input  logic       tx_cond_i,
  input  logic       sel_tx_i,
  input  logic       sel_xoff_i,
  input  logic       xoff_match_i,
  input  logic       xon_i,
  input  logic       cts_i,
  input  logic       rts_i,
  input  logic       auto_cts_i,
  input  logic       auto_rts_i,
  output logic       line_o,
  output logic       tx_o,
  output logic       modem_o,
  output logic       xoff_o,
  output logic       flow_o,
  output logic       xoff_flag_o
);
  logic tx_cond_q, cts_q, rts_q;
  logic tx_rise, flow_edge, xoff_set;

  assign tx_rise   = tx_cond_i & ~tx_cond_q;
  assign xoff_set  = enh_i & xoff_match_i;
  assign flow_edge = enh_i & ((cts_i & ~cts_q & auto_cts_i) |
                              (rts_i & ~rts_q & auto_rts_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o      <= 1'b0;
      tx_o        <= 1'b0;
      modem_o     <= 1'b0;
      xoff_o      <= 1'b0;
      flow_o      <= 1'b0;
      xoff_flag_o <= 1'b0;
      tx_cond_q   <= 1'b0;
      cts_q       <= 1'b0;
      rts_q       <= 1'b0;
    end else begin
      tx_cond_q <= tx_cond_i;
      cts_q     <= cts_i;
      rts_q     <= rts_i;

      if (|lsr_evt_i)    line_o <= 1'b1;
      else if (lsr_rd_i) line_o <= 1'b0;

      if (|msr_evt_i)    modem_o <= 1'b1;
      else if (msr_rd_i) modem_o <= 1'b0;

      if (flow_edge)     flow_o <= 1'b1;
      else if (msr_rd_i) flow_o <= 1'b0;

      // a holding write refills the FIFO: clear beats a coincident rise
      if (thr_wr_i || (isr_rd_i && sel_tx_i)) tx_o <= 1'b0;
      else if (tx_rise)                       tx_o <= 1'b1;

      if (xoff_set)                      xoff_o <= 1'b1;
      else if (isr_rd_i && sel_xoff_i)   xoff_o <= 1'b0;

      if (xoff_set)   xoff_flag_o <= 1'b1;
      else if (xon_i) xoff_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int N = 7
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_rank
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end
  assign any_o = seen[N];
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int TOUT_W     = 6,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             enh_i,
  input  logic [5:0]       ien_i,
  input  logic [1:0]       wlen_i,
  input  logic             baud_tick_i,
  input  logic [3:0]       lsr_evt_i,
  input  logic [3:0]       msr_evt_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             rx_char_i,
  input  logic [LVL_W-1:0] tx_level_i,
  input  logic [LVL_W-1:0] tx_trig_i,
  input  logic             tx_empty_i,
  input  logic             xoff_match_i,
  input  logic             xon_i,
  input  logic             cts_i,
  input  logic             rts_i,
  input  logic             auto_cts_i,
  input  logic             auto_rts_i,
  input  logic             isr_rd_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             rhr_rd_i,
  input  logic             thr_wr_i,
  output logic [7:0]       status_o,
  output logic             irq_o
);
  logic            line_p, tx_p, modem_p, xoff_p, flow_p, xoff_flag, tout_p;
  logic            rx_ready, tx_cond;
  logic [NSRC-1:0] req, grant;
  logic [5:0]      code;

  assign rx_ready = (rx_level_i >= rx_trig_i);
  assign tx_cond  = ien_i[1] & (tx_empty_i | (tx_level_i <= tx_trig_i));

  uart_irq_rx_timeout #(.TOUT_W(TOUT_W)) u_tout (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (baud_tick_i),
    .wlen_i     (wlen_i),
    .nonempty_i (rx_level_i != '0),
    .rx_char_i  (rx_char_i),
    .rhr_rd_i   (rhr_rd_i),
    .tout_o     (tout_p)
  );

  uart_irq_sources u_src (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .enh_i        (enh_i),
    .lsr_evt_i    (lsr_evt_i),
    .lsr_rd_i     (lsr_rd_i),
    .msr_evt_i    (msr_evt_i),
    .msr_rd_i     (msr_rd_i),
    .isr_rd_i     (isr_rd_i),
    .thr_wr_i     (thr_wr_i),
    .tx_cond_i    (tx_cond),
    .sel_tx_i     (grant[SRC_TXRDY]),
    .sel_xoff_i   (grant[SRC_XOFF]),
    .xoff_match_i (xoff_match_i),
    .xon_i        (xon_i),
    .cts_i        (cts_i),
    .rts_i        (rts_i),
    .auto_cts_i   (auto_cts_i),
    .auto_rts_i   (auto_rts_i),
    .line_o       (line_p),
    .tx_o         (tx_p),
    .modem_o      (modem_p),
    .xoff_o       (xoff_p),
    .flow_o       (flow_p),
    .xoff_flag_o  (xoff_flag)
  );

  always_comb begin
    req             = '0;
    req[SRC_LINE]   = line_p   & ien_i[2];
    req[SRC_TOUT]   = tout_p   & ien_i[0];
    req[SRC_RXRDY]  = rx_ready & ien_i[0];
    req[SRC_TXRDY]  = tx_p     & ien_i[1];
    req[SRC_MODEM]  = modem_p  & ien_i[3];
    req[SRC_XOFF]   = xoff_p   & ien_i[4] & enh_i;
    req[SRC_FLOW]   = flow_p   & ien_i[5] & enh_i;
  end

  uart_irq_prio #(.N(NSRC)) u_prio (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (irq_o)
  );

  always_comb begin
    code = CODE_NONE;
    for (int i = 0; i < NSRC; i++)
      if (grant[i]) code = src_code(i);
  end

  // bit 4 follows the sticky Xoff flag, not just the winning code
  assign status_o = {{2{fifo_en_i}}, code[5], code[4] | (xoff_flag & enh_i), code[3:0]};
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk #(
  parameter int LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enh_i,
  input logic [5:0]       ien_i,
  input logic [3:0]       lsr_evt_i,
  input logic [LVL_W-1:0] rx_level_i,
  input logic [LVL_W-1:0] rx_trig_i,
  input logic             rhr_rd_i,
  input logic             thr_wr_i,
  input logic [7:0]       status_o,
  input logic             irq_o
);
  AST_LSR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|lsr_evt_i) && ien_i[2]) |=> (status_o[3:0] == 4'b0110 || !ien_i[2])); // R4

  AST_RXRDY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i >= rx_trig_i && ien_i[0]) |-> irq_o); // R5

  AST_TOUT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rhr_rd_i |=> (status_o[3:0] != 4'b1100)); // R6

  AST_TX_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> (status_o[3:0] != 4'b0010)); // R7

  AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (status_o[3:0] == 4'b0001 && !status_o[5])); // R3

  AST_ENH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_i |-> (status_o[5:4] == 2'b00)); // R12
endmodule

bind uart_irq_status uart_irq_status_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enh_i      (enh_i),
  .ien_i      (ien_i),
  .lsr_evt_i  (lsr_evt_i),
  .rx_level_i (rx_level_i),
  .rx_trig_i  (rx_trig_i),
  .rhr_rd_i   (rhr_rd_i),
  .thr_wr_i   (thr_wr_i),
  .status_o   (status_o),
  .irq_o      (irq_o)
);

// File: tb/uart_irq_status_test.sv
module uart_irq_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W      = 8;
  localparam int NVEC       = 13;

  // {source mask [14:8] (0 line,1 tout,2 rx,3 tx,4 modem,5 xoff,6 flow), expected status [7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {7'h00, 8'hC1}, {7'h01, 8'hC6}, {7'h02, 8'hCC}, {7'h04, 8'hC4},
    {7'h08, 8'hC2}, {7'h10, 8'hC0}, {7'h20, 8'hD0}, {7'h40, 8'hE0},
    {7'h7F, 8'hD6}, {7'h7E, 8'hDC}, {7'h5C, 8'hC4}, {7'h58, 8'hC2},
    {7'h50, 8'hC0}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             fifo_en_i, enh_i;
  logic [5:0]       ien_i;
  logic [1:0]       wlen_i;
  logic             baud_tick_i;
  logic [3:0]       lsr_evt_i, msr_evt_i;
  logic [LVL_W-1:0] rx_level_i, rx_trig_i, tx_level_i, tx_trig_i;
  logic             rx_char_i, tx_empty_i, xoff_match_i, xon_i;
  logic             cts_i, rts_i, auto_cts_i, auto_rts_i;
  logic             isr_rd_i, lsr_rd_i, msr_rd_i, rhr_rd_i, thr_wr_i;
  logic [7:0]       status_o;
  logic             irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  uart_irq_status uut (.*);

  task automatic step();
    @(negedge clk_i);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic defaults();
    fifo_en_i = 1; enh_i = 1; ien_i = 6'h3F; wlen_i = 0; baud_tick_i = 1;
    lsr_evt_i = 0; msr_evt_i = 0; rx_level_i = 0; rx_trig_i = 8; rx_char_i = 0;
    tx_level_i = 20; tx_trig_i = 8; tx_empty_i = 0; xoff_match_i = 0; xon_i = 0;
    cts_i = 0; rts_i = 0; auto_cts_i = 0; auto_rts_i = 0;
    isr_rd_i = 0; lsr_rd_i = 0; msr_rd_i = 0; rhr_rd_i = 0; thr_wr_i = 0;
  endtask

  task automatic do_reset();
    defaults();
    rst_ni = 0;
    step();
    rst_ni = 1;
    step();
  endtask

  task automatic raise(input logic [6:0] m);
    rx_level_i = m[2] ? 8'd8 : (m[1] ? 8'd1 : 8'd0);
    if (m[1]) repeat (60) step();
    if (m[0]) begin lsr_evt_i = 4'b0010; step(); lsr_evt_i = 0; end
    if (m[3]) begin tx_empty_i = 1; step(); end
    if (m[4]) begin msr_evt_i = 4'b0001; step(); msr_evt_i = 0; end
    if (m[5]) begin xoff_match_i = 1; step(); xoff_match_i = 0; end
    if (m[6]) begin auto_cts_i = 1; cts_i = 1; step(); end
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    defaults();
    rst_ni = 0;
    step();
    // R1 / R11 reset state
    check("R1 reset status", status_o, 8'hC1);
    check("R1 reset irq", {7'b0, irq_o}, 8'h00);
    fifo_en_i = 0; #1;
    check("R11 fifo off", status_o, 8'h01);
    fifo_en_i = 1;
    rst_ni = 1;
    step();

    // R2 / R3 priority table
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      raise(VEC[v][14:8]);
      check($sformatf("R2 vec %0d", v), status_o, VEC[v][7:0]);
      check($sformatf("R3 irq vec %0d", v), {7'b0, irq_o}, {7'b0, ~VEC[v][0]});
    end

    // R4 line status set and clear
    do_reset();
    lsr_evt_i = 4'b1000; step(); lsr_evt_i = 0;
    check("R4 set", status_o, 8'hC6);
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    check("R4 clear", status_o, 8'hC1);

    // R5 rx ready level edges
    do_reset();
    rx_level_i = 8; #1;
    check("R5 at trigger", status_o, 8'hC4);
    rx_level_i = 7; #1;
    check("R5 below trigger", status_o, 8'hC1);
    rx_level_i = 0; step();

    // R6 time-out boundary, wlen 3 -> 52
    do_reset();
    wlen_i = 3; rx_level_i = 1; rx_char_i = 1; step(); rx_char_i = 0;
    repeat (51) step();
    check("R6 before limit 52", status_o, 8'hC1);
    step();
    check("R6 at limit 52", status_o, 8'hCC);
    rhr_rd_i = 1; step(); rhr_rd_i = 0;
    check("R6 rhr read clears", status_o, 8'hC1);
    // restart by character, wlen 0 -> 40
    wlen_i = 0; rx_char_i = 1; step(); rx_char_i = 0;
    repeat (20) step();
    rx_char_i = 1; step(); rx_char_i = 0;
    repeat (39) step();
    check("R6 restart before 40", status_o, 8'hC1);
    step();
    check("R6 restart at 40", status_o, 8'hCC);

    // R7 tx ready clears
    do_reset();
    tx_empty_i = 1; step();
    check("R7 set", status_o, 8'hC2);
    isr_rd_i = 1; step(); isr_rd_i = 0;
    check("R7 isr read clears", status_o, 8'hC1);
    tx_empty_i = 0; step(); tx_empty_i = 1; step();
    check("R7 reraise", status_o, 8'hC2);
    thr_wr_i = 1; step(); thr_wr_i = 0;
    check("R7 thr write clears", status_o, 8'hC1);
    tx_empty_i = 0; step(); tx_level_i = 8; step();
    check("R7 level at trigger", status_o, 8'hC2);
    lsr_evt_i = 1; step(); lsr_evt_i = 0;
    isr_rd_i = 1; step(); isr_rd_i = 0;
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    check("R7 read while masked keeps tx", status_o, 8'hC2);

    // R8 modem and flow cleared by modem read
    do_reset();
    msr_evt_i = 4'b0100; step(); msr_evt_i = 0;
    auto_rts_i = 1; rts_i = 1; step();
    check("R8 modem over flow", status_o, 8'hC0);
    msr_rd_i = 1; step(); msr_rd_i = 0;
    check("R8 modem read clears both", status_o, 8'hC1);

    // R9 sticky Xoff
    do_reset();
    xoff_match_i = 1; step(); xoff_match_i = 0;
    check("R9 set", status_o, 8'hD0);
    isr_rd_i = 1; step(); isr_rd_i = 0;
    check("R9 isr read keeps bit4", status_o, 8'hD1);
    xon_i = 1; step(); xon_i = 0;
    check("R9 xon drops bit4", status_o, 8'hC1);

    // R10 flow edges need auto enable
    do_reset();
    cts_i = 1; step();
    check("R10 cts edge without auto ignored", status_o, 8'hC1);
    cts_i = 0; auto_cts_i = 1; step(); cts_i = 1; step();
    check("R10 cts edge with auto", status_o, 8'hE0);

    // R12 enables and enhanced mode
    do_reset();
    ien_i = 6'h3B; lsr_evt_i = 1; step(); lsr_evt_i = 0;
    check("R12 line masked", status_o, 8'hC1);
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    ien_i = 6'h3F; enh_i = 0;
    xoff_match_i = 1; step(); xoff_match_i = 0;
    auto_cts_i = 1; cts_i = 1; step();
    check("R12 enhanced off", status_o, 8'hC1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule